// File: doc/BRIEF.md
# Divide-by-Three Processor Clock Generator

This block derives a processor clock from a faster input clock. It produces one processor-clock period for every three input periods, and the processor clock is high for one input period out of each three. From the processor clock it derives a peripheral clock at half that rate with equal high and low times. It also retimes a reset request so that the reset output moves only when the processor clock falls. The whole design runs in one clocking domain, `clk_i`. Each of the two candidate input clocks is presented as a one-cycle tick input, and every tick of the selected source counts as one input-clock period. A static select input, which is changed only while the block is in reset, picks which tick input drives the divider.

A clear input lets several of these generators line up their phase to one shared event. The clear passes through two flip-flop stages, and each stage advances on ticks of the selected source. While the synchronized clear is high, the divider is frozen in a fixed phase and both clock outputs are held low. Once it drops, the first processor-clock high phase begins on the very next tick, so every generator released by the same event runs in step.

Top module: `cgen_top`

## Requirements
- R1: When `src_sel_i` is 1, `src_tick_b_i` drives the divider. When it is 0, `src_tick_a_i` drives the divider. The tick input that is not selected has no effect on any output.
- R2: With clear inactive, `cpu_clk_o` repeats every three selected ticks. It is high for exactly one tick interval and low for the other two.
- R3: After `rst_ni` is released with clear inactive, `cpu_clk_o` goes high on the first selected tick.
- R4: Each level of `clr_i` is sampled on a selected tick and reaches the divider two selected ticks later.
- R5: On every selected tick at which the synchronized clear is high, `cpu_clk_o` and `per_clk_o` are driven low and the divider is returned to its fixed hold phase.
- R6: The first selected tick at which the synchronized clear is low drives `cpu_clk_o` high. The three-tick pattern of R2 continues from there.
- R7: `per_clk_o` toggles on each rise of `cpu_clk_o`. It is therefore high for three selected ticks and low for three, and it goes high together with the first `cpu_clk_o` high phase after reset or clear.
- R8: `rst_o` changes only on the `clk_i` edge at which `cpu_clk_o` falls from a running high phase. It then takes the value that `rst_req_i` had one `clk_i` cycle earlier.
- R9: While `rst_ni` is low, and on its release, `cpu_clk_o` = 0, `per_clk_o` = 0 and `rst_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Single clock of the block |
| rst_ni | input | 1 | Synchronous active-low reset |
| src_sel_i | input | 1 | Static source select: 0 = tick A, 1 = tick B |
| src_tick_a_i | input | 1 | One-cycle tick per period of input clock A |
| src_tick_b_i | input | 1 | One-cycle tick per period of input clock B |
| clr_i | input | 1 | Phase-alignment clear, active high, asynchronous to the ticks |
| rst_req_i | input | 1 | Reset request, active high |
| cpu_clk_o | output | 1 | Processor clock, one-third rate, one-third duty |
| per_clk_o | output | 1 | Peripheral clock, half the processor rate, 50% duty |
| rst_o | output | 1 | Reset output, updated on processor-clock falls |

## Verification
The bench uses the default parameters: a divide ratio of three and two clear stages. At these values one full peripheral period is only six ticks, so each phase of the divider is reached within a short run. The sweep repeats the same stimulus for both select values and for three tick densities: every cycle, every other cycle and a pseudo-random pattern. Throughout, the source that is not selected carries the opposite pattern. Clear pulses from one to six cycles long fall on every divider phase, including a clear that lands during a high phase and a pulse too short to be caught on a sparse tick.

// File: rtl/cgen_pkg.sv
// Shared definitions for the clock generator.
// Assumes: single clock domain; every "input period" is one source tick.
package cgen_pkg;

    // Edge events of the processor clock, valid on the clk_i cycle they occur.
    typedef struct packed {
        logic rise;
        logic fall;
    } cgen_evt_t;

    // Counter width needed for a divide ratio.
    function automatic int cnt_width(input int ratio);
        return (ratio > 2) ? $clog2(ratio) : 1;
    endfunction

endpackage

// File: rtl/cgen_clr_sync.sv
// Multi-stage synchronizer for the clear input. It shifts only on selected
// source ticks, so the stages behave like flops on the input clock.
// Assumes: STAGES >= 2.
module cgen_clr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic clr_i,
    output logic clr_sync_o
);
    logic [STAGES-1:0] stg_q;

    // Shift the clear level one stage per selected tick.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            stg_q <= '0;
        else if (tick_i)
            stg_q <= {stg_q[STAGES-2:0], clr_i};
    end

    assign clr_sync_o = stg_q[STAGES-1];

    // R4
    sync_moves_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(clr_sync_o) |-> $past(tick_i));

endmodule

// File: rtl/cgen_divider.sv
// Divide-by-N counter making the processor clock. It is high for one tick in
// each N. A synchronized clear freezes it in its last phase with the output
// low, so the next running tick starts a high phase.
// Assumes: DIV >= 3; tick_i is a one-cycle strobe.
module cgen_divider
    import cgen_pkg::*;
#(
    parameter int DIV = 3
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      tick_i,
    input  logic      hold_i,
    output logic      cpu_clk_o,
    output cgen_evt_t evt_o
);
    localparam int CW = cnt_width(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q, cnt_nxt;
    logic          cpu_q;
    logic          run;

    // Next count and the edge events of this tick.
    always_comb begin
        run        = tick_i && !hold_i;
        cnt_nxt    = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        evt_o.rise = run && (cnt_nxt == '0);
        evt_o.fall = run && cpu_q;
    end

    // Count on ticks; the clear forces the hold phase.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= LAST;
            cpu_q <= 1'b0;
        end else if (tick_i) begin
            if (hold_i) begin
                cnt_q <= LAST;
                cpu_q <= 1'b0;
            end else begin
                cnt_q <= cnt_nxt;
                cpu_q <= (cnt_nxt == '0);
            end
        end
    end

    assign cpu_clk_o = cpu_q;

    // R2
    one_tick_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && cpu_q) |=> !cpu_q);
    // R5
    hold_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && hold_i) |=> !cpu_clk_o);
    // R6
    release_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !hold_i && $past(tick_i && hold_i)) |=> cpu_clk_o);
    // R2
    out_moves_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(cpu_clk_o) |-> $past(tick_i));

endmodule

// File: rtl/cgen_pclk.sv
// Peripheral clock: toggles on each processor-clock rise, giving half the
// processor rate at 50% duty. It is held low while the clear is active.
// Assumes: rise_i and hold_i are qualified with the selected tick.
module cgen_pclk (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rise_i,
    input  logic hold_i,
    output logic per_clk_o
);
    logic per_q;

    // Toggle on rises, force low on a held tick.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            per_q <= 1'b0;
        else if (hold_i)
            per_q <= 1'b0;
        else if (rise_i)
            per_q <= !per_q;
    end

    assign per_clk_o = per_q;

    // R7
    per_moves_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(per_q) |-> $past(rise_i || hold_i));

endmodule

// File: rtl/cgen_rst_sync.sv
// Reset retiming: the request is registered every cycle, and the output
// loads that registered value only on a processor-clock fall event.
// Assumes: fall_i is a one-cycle strobe from the divider.
module cgen_rst_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fall_i,
    input  logic req_i,
    output logic rst_o
);
    logic req_q, out_q;

    // Capture the request, then move it out on a fall.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            req_q <= 1'b1;
            out_q <= 1'b1;
        end else begin
            req_q <= req_i;
            if (fall_i)
                out_q <= req_q;
        end
    end

    assign rst_o = out_q;

    // R8
    rst_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(rst_o) |-> $past(fall_i));

endmodule

// File: rtl/cgen_top.sv
// Clock generator top: source select, clear synchronizer, divider,
// peripheral clock and reset retiming.
// Assumes: src_sel_i changes only while rst_ni is low.
module cgen_top
    import cgen_pkg::*;
#(
    parameter int DIV        = 3,
    parameter int CLR_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic src_sel_i,
    input  logic src_tick_a_i,
    input  logic src_tick_b_i,
    input  logic clr_i,
    input  logic rst_req_i,
    output logic cpu_clk_o,
    output logic per_clk_o,
    output logic rst_o
);
    logic      tick;
    logic      clr_sync;
    cgen_evt_t evt;

    // Pick the tick source.
    always_comb tick = src_sel_i ? src_tick_b_i : src_tick_a_i;

    cgen_clr_sync #(.STAGES(CLR_STAGES)) u_clr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick),
        .clr_i      (clr_i),
        .clr_sync_o (clr_sync)
    );

    cgen_divider #(.DIV(DIV)) u_div (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick),
        .hold_i    (clr_sync),
        .cpu_clk_o (cpu_clk_o),
        .evt_o     (evt)
    );

    cgen_pclk u_pclk (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rise_i    (evt.rise),
        .hold_i    (tick && clr_sync),
        .per_clk_o (per_clk_o)
    );

    cgen_rst_sync u_rst (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .fall_i (evt.fall),
        .req_i  (rst_req_i),
        .rst_o  (rst_o)
    );

    // R1
    idle_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick |=> $stable(cpu_clk_o) && $stable(per_clk_o));

endmodule

// File: tb/cgen_top_tb_top.sv
// Sweep bench: both sources, three tick densities, clear pulses of many
// lengths. The expected outputs come from a count of running ticks.
module cgen_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, ta = 1'b0, tb = 1'b0, clr = 1'b0, req = 1'b0;
    logic cpu, per, rsto;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // Model state.
    int   m;
    logic h1, h2, req_ff, e_cpu, e_per, e_rst;
    logic [7:0] lfsr;

    always #5 clk = !clk;

    cgen_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .src_sel_i(sel),
        .src_tick_a_i(ta), .src_tick_b_i(tb), .clr_i(clr),
        .rst_req_i(req), .cpu_clk_o(cpu), .per_clk_o(per), .rst_o(rsto)
    );

    task automatic chk(input logic act, input logic exp, input string msg);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", msg, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst_n = 1'b0; sel = s; ta = 0; tb = 0; clr = 0; req = 0;
        repeat (3) @(negedge clk);
        // R9 outputs while reset is held
        chk(cpu, 1'b0, "R9 cpu in reset");
        chk(per, 1'b0, "R9 per in reset");
        chk(rsto, 1'b1, "R9 rst in reset");
        rst_n = 1'b1;
        m = 0; h1 = 0; h2 = 0; req_ff = 1; e_cpu = 0; e_per = 0; e_rst = 1;
    endtask

    // One clk_i cycle: drive, update model, check after the edge.
    task automatic step(input logic tick_sel, input logic tick_oth,
                        input logic c, input logic r, input string scen);
        logic old_req, held;
        string tag;
        @(negedge clk);
        if (sel) begin tb = tick_sel; ta = tick_oth; end
        else     begin ta = tick_sel; tb = tick_oth; end
        clr = c; req = r;
        old_req = req_ff; req_ff = r;
        held = 1'b0;
        if (tick_sel) begin
            held = h2;
            h2 = h1; h1 = c;
            if (held) begin
                m = 0; e_cpu = 0; e_per = 0;
            end else begin
                m++;
                e_cpu = ((m - 1) % 3 == 0);
                e_per = (((m - 1) / 3) % 2 == 0);
                if ((m - 1) % 3 == 1) e_rst = old_req;
            end
        end
        @(posedge clk); #1;
        if (held)        tag = "R4 R5 clear hold";
        else if (m == 1) tag = "R3 R6 first high";
        else             tag = "R2 cpu pattern";
        chk(cpu, e_cpu, {scen, " ", tag});
        chk(per, e_per, {scen, " R7 per clock"});
        chk(rsto, e_rst, {scen, " R8 reset retime"});
    endtask

    function automatic logic pat(input int p, input int i);
        case (p)
            0: return 1'b1;
            1: return i[0];
            default: return lfsr[0] ^ lfsr[3];
        endcase
    endfunction

    initial begin
        lfsr = 8'hA5;
        for (int s = 0; s < 2; s++) begin
            for (int p = 0; p < 3; p++) begin
                int n;
                logic t;
                do_reset(s[0]);
                n = 0;
                // R1 other source carries the opposite pattern throughout
                for (int i = 0; i < 48; i++) begin
                    t = pat(p, n); n++;
                    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                    step(t, !t, 1'b0, (i / 7) % 2 == 1, "R1 run");
                end
                for (int len = 1; len <= 6; len++) begin
                    for (int i = 0; i < len; i++) begin
                        t = pat(p, n); n++;
                        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                        step(t, !t, 1'b1, len[0], "R1 clear");
                    end
                    for (int i = 0; i < 19 + len; i++) begin
                        t = pat(p, n); n++;
                        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                        step(t, !t, 1'b0, (i / 5) % 2 == 0, "R1 resume");
                    end
                end
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule